// File: doc/BRIEF.md
# Serial Flash Controller Register Bank

This block is the software-visible register file of a serial flash controller. A host reaches it over a simple word-addressed bus with a single-cycle strobe. The bus carries a byte address, and the register is chosen by the address shifted right by two. The bank holds the controller configuration, a global enable, a slave idle count, the transmit and receive FIFO threshold levels, an interrupt mask, sticky interrupt status and a fixed module identification word. It drives all of these values out to the rest of the controller.

Read data is combinational in the cycle the strobe is high. Each register has its own read mask:
- Bits with no meaning read as zero.
- Write-only registers always read as zero.
- Reading the status register clears it at the clock edge that ends the access.

The FIFOs and the shift engine sit outside the block:
- Events from them arrive as single-cycle pulses and are merged into the sticky status.
- A receive word is presented on an input port and comes back through the RX data register in the byte order selected by the configuration.
- Transmit writes and receive reads produce one-cycle strobes towards the FIFOs.

Top module: `flashctl_regbank`

## Requirements
- R1: After synchronous reset, the registers hold these values:

  | Register | Reset value |
  |---|---|
  | Configuration | 0x00020000 (mode-fail generation enable, bit 17, set) |
  | Slave idle count | 0xFF |
  | TX threshold | 1 |
  | RX threshold | 1 |
  | Enable | 0 |
  | Interrupt mask | 0 |
  | Interrupt status | 0 |

  The interrupt output is low after reset.
- R2: The identification word at byte address 0xFC reads 0x01090106 (the value ANDed with the mask 0x01FFFFFF), and writes to it have no effect.
- R3: The configuration register (0x00) stores and returns only the bits in 0x0402FFFF. The manual-start bit 16 always reads 0. Writing a 1 to bit 16 raises `man_start` for that write cycle only.
- R4: The following registers return only part of their width:

  | Register | Address | Bits returned |
  |---|---|---|
  | Enable | 0x14 | bit 0 |
  | Slave idle count | 0x24 | low 8 bits |
  | TX threshold | 0x28 | low 8 bits |
  | RX threshold | 0x2C | low 8 bits |

- R5: The interrupt-enable (0x08), interrupt-disable (0x0C) and TX data (0x1C) registers always read 0. A write to 0x1C raises `tx_push` for that cycle, with `tx_data` equal to the written word.
- R6: A write to 0x08 sets the written bits in the 7-bit interrupt mask. A write to 0x0C clears them. The mask reads back at 0x10 in bits 6:0.
- R7: A read of the status register (0x04) returns the 7 status bits as they were before the access, and then clears all of them. An event arriving in the same cycle as the clearing read remains set afterwards.
- R8: A pulse on `evt_in[i]` sets status bit i, and the bit stays set until a status read. `irq` is high exactly when some status bit is set and its mask bit is set. Writes to the status address do not change status.
- R9: A read of RX data (0x20) raises `rx_pop` for that cycle. The read returns `rx_word` unchanged when configuration bit 26 is 0, and with its four bytes reversed when bit 26 is 1.
- R10: Reads of addresses that map to no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high for a read |
| rx_word | input | 32 | Head word of the receive FIFO |
| evt_in | input | 7 | Single-cycle interrupt event pulses |
| cfg_out | output | 32 | Stored configuration |
| enable_out | output | 1 | Controller enable |
| idle_cnt | output | 8 | Slave idle count |
| tx_thr | output | 8 | TX FIFO threshold |
| rx_thr | output | 8 | RX FIFO threshold |
| man_start | output | 1 | Manual start strobe |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 32 | Transmit FIFO push data |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four behaviours on every cycle:
- every pulsed event is visible in the status the next cycle;
- a clearing read leaves only the events of that same cycle;
- bits set through the enable register are present in the mask;
- write-only and identification reads return their fixed values.

Only the bench scenarios can show the rest:
- reset values;
- per-register truncation of written data;
- the manual-start bit being absent from readback;
- interrupt gating by the mask;
- byte reversal of receive data, which depend on sequences of writes followed by reads.

// File: rtl/flashctl_regbank_pkg.sv
// Shared widths, word offsets and configuration field positions for the
// flash controller register bank.
package flashctl_regbank_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int IRQ_W   = 7;
    localparam int CNT_W   = 8;
    localparam int WIDX_W  = ADDR_W - 2;

    // word indices (byte address >> 2)
    localparam logic [WIDX_W-1:0] W_CFG  = 6'h00;
    localparam logic [WIDX_W-1:0] W_STAT = 6'h01;
    localparam logic [WIDX_W-1:0] W_IEN  = 6'h02;
    localparam logic [WIDX_W-1:0] W_IDIS = 6'h03;
    localparam logic [WIDX_W-1:0] W_MASK = 6'h04;
    localparam logic [WIDX_W-1:0] W_ENA  = 6'h05;
    localparam logic [WIDX_W-1:0] W_TXD  = 6'h07;
    localparam logic [WIDX_W-1:0] W_RXD  = 6'h08;
    localparam logic [WIDX_W-1:0] W_IDLE = 6'h09;
    localparam logic [WIDX_W-1:0] W_TTHR = 6'h0A;
    localparam logic [WIDX_W-1:0] W_RTHR = 6'h0B;
    localparam logic [WIDX_W-1:0] W_ID   = 6'h3F;

    // configuration fields
    localparam int CFG_MSTART_BIT = 16;
    localparam int CFG_MFGEN_BIT  = 17;
    localparam int CFG_ENDIAN_BIT = 26;
    localparam logic [DATA_W-1:0] CFG_KEEP  = 32'h0402_FFFF;
    localparam logic [DATA_W-1:0] CFG_RESET = 32'h0000_0001 << CFG_MFGEN_BIT;

    localparam logic [DATA_W-1:0] ID_VALUE = 32'h0109_0106;
    localparam logic [DATA_W-1:0] ID_MASK  = 32'h01FF_FFFF;
    localparam logic [CNT_W-1:0]  IDLE_RESET = 8'hFF;
    localparam logic [CNT_W-1:0]  THR_RESET  = 8'h01;
endpackage

// File: rtl/flashctl_cfg_regs.sv
// Configuration, enable, idle count and threshold registers.
// Assumes: wr_en is a one-cycle write strobe; widx is the decoded word index.
module flashctl_cfg_regs
    import flashctl_regbank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     cfg_q,
    output logic              ena_q,
    output logic [CW-1:0]     idle_q,
    output logic [CW-1:0]     tthr_q,
    output logic [CW-1:0]     rthr_q,
    output logic              man_start
);
    // Storage update on writes; the manual-start bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET;
            ena_q  <= 1'b0;
            idle_q <= IDLE_RESET;
            tthr_q <= THR_RESET;
            rthr_q <= THR_RESET;
        end else if (wr_en) begin
            case (widx)
                W_CFG:  cfg_q  <= wdata & CFG_KEEP;
                W_ENA:  ena_q  <= wdata[0];
                W_IDLE: idle_q <= wdata[CW-1:0];
                W_TTHR: tthr_q <= wdata[CW-1:0];
                W_RTHR: rthr_q <= wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    // One-cycle manual start strobe on a config write with bit 16 set.
    always_comb man_start = wr_en && (widx == W_CFG) && wdata[CFG_MSTART_BIT];
endmodule

// File: rtl/flashctl_irq_ctrl.sv
// Sticky interrupt status, mask set/clear and interrupt output.
// Assumes: evt_in bits are single-cycle pulses; rd_clr is high for the one
// cycle of a status read. A same-cycle event survives the clear.
module flashctl_irq_ctrl
    import flashctl_regbank_pkg::*;
#(
    parameter int IW = IRQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [IW-1:0] wbits,
    input  logic          rd_clr,
    input  logic [IW-1:0] evt_in,
    output logic [IW-1:0] status_q,
    output logic [IW-1:0] mask_q,
    output logic          irq
);
    // Status: clear on read, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (rd_clr ? '0 : status_q) | evt_in;
    end

    // Mask: enable-writes set bits, disable-writes clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (set_en) mask_q <= mask_q | wbits;
        else if (clr_en) mask_q <= mask_q & ~wbits;
    end

    // Interrupt request from enabled pending bits.
    always_comb irq = |(status_q & mask_q);

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_clr) |-> status_q == $past(evt_in));

    // R8
    sticky_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_q & $past(evt_in)) == $past(evt_in));

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(set_en) |-> (mask_q & $past(wbits)) == $past(wbits));
endmodule

// File: rtl/flashctl_rd_mux.sv
// Read-data selection with per-register masks and RX byte-order select.
// Assumes: all inputs are register outputs or the FIFO head word.
module flashctl_rd_mux
    import flashctl_regbank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IRQ_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DW-1:0]     cfg_q,
    input  logic              ena_q,
    input  logic [CW-1:0]     idle_q,
    input  logic [CW-1:0]     tthr_q,
    input  logic [CW-1:0]     rthr_q,
    input  logic [IW-1:0]     status_q,
    input  logic [IW-1:0]     mask_q,
    input  logic [DW-1:0]     rx_word,
    output logic [DW-1:0]     rdata
);
    localparam int NBYTES = DW / 8;
    logic [DW-1:0] rx_rev;

    // Byte-reversed view of the receive word.
    for (genvar g = 0; g < NBYTES; g++) begin : g_swap
        assign rx_rev[8*g +: 8] = rx_word[8*(NBYTES-1-g) +: 8];
    end

    // Masked register select; write-only and unmapped words return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (widx)
                W_CFG:  rdata = cfg_q & CFG_KEEP & ~(DW'(1) << CFG_MSTART_BIT);
                W_STAT: rdata = DW'(status_q);
                W_MASK: rdata = DW'(mask_q);
                W_ENA:  rdata = DW'(ena_q);
                W_RXD:  rdata = cfg_q[CFG_ENDIAN_BIT] ? rx_rev : rx_word;
                W_IDLE: rdata = DW'(idle_q);
                W_TTHR: rdata = DW'(tthr_q);
                W_RTHR: rdata = DW'(rthr_q);
                W_ID:   rdata = ID_VALUE & ID_MASK;
                default: rdata = '0;
            endcase
        end
    end

    // R5
    wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (widx == W_IEN || widx == W_IDIS || widx == W_TXD) |-> rdata == '0);

    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && widx == W_ID |-> rdata == 32'h0109_0106);
endmodule

// File: rtl/flashctl_regbank.sv
// Top of the flash controller register bank: address decode and wiring.
// Assumes: one access per bus_en cycle; read data is used in that cycle.
module flashctl_regbank
    import flashctl_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [IRQ_W-1:0]  evt_in,
    output logic [DATA_W-1:0] cfg_out,
    output logic              enable_out,
    output logic [CNT_W-1:0]  idle_cnt,
    output logic [CNT_W-1:0]  tx_thr,
    output logic [CNT_W-1:0]  rx_thr,
    output logic              man_start,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_pop,
    output logic              irq
);
    logic [WIDX_W-1:0] widx;
    logic              wr_en, rd_en;
    logic [IRQ_W-1:0]  status_q, mask_q;

    // Access decode.
    always_comb begin
        widx    = bus_addr[ADDR_W-1:2];
        wr_en   = bus_en && bus_we;
        rd_en   = bus_en && !bus_we;
        tx_push = wr_en && (widx == W_TXD);
        tx_data = bus_wdata;
        rx_pop  = rd_en && (widx == W_RXD);
    end

    flashctl_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx), .wdata(bus_wdata),
        .cfg_q(cfg_out), .ena_q(enable_out), .idle_q(idle_cnt),
        .tthr_q(tx_thr), .rthr_q(rx_thr), .man_start(man_start)
    );

    flashctl_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_en(wr_en && widx == W_IEN), .clr_en(wr_en && widx == W_IDIS),
        .wbits(bus_wdata[IRQ_W-1:0]), .rd_clr(rd_en && widx == W_STAT),
        .evt_in(evt_in), .status_q(status_q), .mask_q(mask_q), .irq(irq)
    );

    flashctl_rd_mux u_mux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .widx(widx),
        .cfg_q(cfg_out), .ena_q(enable_out), .idle_q(idle_cnt),
        .tthr_q(tx_thr), .rthr_q(rx_thr), .status_q(status_q), .mask_q(mask_q),
        .rx_word(rx_word), .rdata(bus_rdata)
    );
endmodule

// File: tb/flashctl_regbank_tb_top.sv
// Directed bench for the flash controller register bank.
module flashctl_regbank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rx_word = '0, cfg_out, tx_data;
    logic [6:0]  evt_in = '0;
    logic        enable_out, man_start, tx_push, rx_pop, irq;
    logic [7:0]  idle_cnt, tx_thr, rx_thr;

    int n_chk = 0, n_bad = 0;
    logic        seen_mstart, seen_push, seen_pop;
    logic [31:0] seen_txd;

    always #(CLK_PERIOD/2) clk = ~clk;

    flashctl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_word(rx_word), .evt_in(evt_in), .cfg_out(cfg_out),
        .enable_out(enable_out), .idle_cnt(idle_cnt), .tx_thr(tx_thr),
        .rx_thr(rx_thr), .man_start(man_start), .tx_push(tx_push),
        .tx_data(tx_data), .rx_pop(rx_pop), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        #1 seen_mstart = man_start; seen_push = tx_push; seen_txd = tx_data;
        @(posedge clk); #1 bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [6:0] ev, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a; evt_in = ev;
        #1 d = bus_rdata; seen_pop = rx_pop;
        @(posedge clk); #1 bus_en = 0; evt_in = '0;
    endtask

    task automatic pulse(input logic [6:0] ev);
        @(negedge clk); evt_in = ev;
        @(posedge clk); #1 evt_in = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, 0, d); chk("R1 cfg reset", d, 32'h0002_0000);
        rd(8'h24, 0, d); chk("R1 idle reset", d, 32'hFF);
        rd(8'h28, 0, d); chk("R1 tx thr reset", d, 1);
        rd(8'h2C, 0, d); chk("R1 rx thr reset", d, 1);
        rd(8'h14, 0, d); chk("R1 enable reset", d, 0);
        rd(8'h10, 0, d); chk("R1 mask reset", d, 0);
        rd(8'h04, 0, d); chk("R1 status reset", d, 0);
        chk("R1 irq reset", {31'b0, irq}, 0);
    endtask

    task automatic t_id;
        logic [31:0] d;
        rd(8'hFC, 0, d); chk("R2 id", d, 32'h0109_0106);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'hFC, 0, d); chk("R2 id after write", d, 32'h0109_0106);
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R3 man_start strobe", {31'b0, seen_mstart}, 1);
        @(negedge clk); chk("R3 man_start one cycle", {31'b0, man_start}, 0);
        rd(8'h00, 0, d); chk("R3 cfg readback", d, 32'h0402_FFFF & ~32'h0001_0000);
        wr(8'h00, 32'h0000_1234);
        chk("R3 no strobe bit16=0", {31'b0, seen_mstart}, 0);
        rd(8'h00, 0, d); chk("R3 cfg readback 2", d, 32'h0000_1234);
    endtask

    task automatic t_masks;
        logic [31:0] d;
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, 0, d); chk("R4 enable bit0", d, 1);
        wr(8'h24, 32'h0000_1234);
        rd(8'h24, 0, d); chk("R4 idle low byte", d, 32'h34);
        wr(8'h28, 32'hABCD_0077);
        rd(8'h28, 0, d); chk("R4 tx thr low byte", d, 32'h77);
        wr(8'h2C, 32'h0000_0105);
        rd(8'h2C, 0, d); chk("R4 rx thr low byte", d, 32'h05);
    endtask

    task automatic t_wo;
        logic [31:0] d;
        wr(8'h1C, 32'hCAFE_F00D);
        chk("R5 tx_push", {31'b0, seen_push}, 1);
        chk("R5 tx_data", seen_txd, 32'hCAFE_F00D);
        rd(8'h1C, 0, d); chk("R5 txdata reads 0", d, 0);
        rd(8'h08, 0, d); chk("R5 ien reads 0", d, 0);
        rd(8'h0C, 0, d); chk("R5 idis reads 0", d, 0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(8'h08, 32'hFFFF_FF55);
        rd(8'h10, 0, d); chk("R6 mask set", d, 32'h55);
        wr(8'h0C, 32'h0000_0005);
        rd(8'h10, 0, d); chk("R6 mask clear", d, 32'h50);
        pulse(7'h01);
        chk("R8 masked event no irq", {31'b0, irq}, 0);
        pulse(7'h10);
        chk("R8 enabled event irq", {31'b0, irq}, 1);
        wr(8'h04, 32'h0);
        chk("R8 status write ignored irq", {31'b0, irq}, 1);
        rd(8'h04, 0, d); chk("R7 status value", d, 32'h11);
        chk("R7 irq after clear", {31'b0, irq}, 0);
        rd(8'h04, 0, d); chk("R7 status cleared", d, 0);
        pulse(7'h02);
        rd(8'h04, 7'h40, d); chk("R7 read during event", d, 32'h02);
        chk("R8 same-cycle event irq", {31'b0, irq}, 1);
        rd(8'h04, 0, d); chk("R7 same-cycle event kept", d, 32'h40);
    endtask

    task automatic t_rx;
        logic [31:0] d;
        rx_word = 32'h1122_3344;
        wr(8'h00, 32'h0);
        rd(8'h20, 0, d); chk("R9 rx little", d, 32'h1122_3344);
        chk("R9 rx_pop", {31'b0, seen_pop}, 1);
        wr(8'h00, 32'h0400_0000);
        rd(8'h20, 0, d); chk("R9 rx big", d, 32'h4433_2211);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(8'h18, 0, d); chk("R10 unmapped 0x18", d, 0);
        rd(8'h30, 0, d); chk("R10 unmapped 0x30", d, 0);
        chk("R10 no pop", {31'b0, seen_pop}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset; t_id; t_cfg; t_masks; t_wo; t_irq; t_rx; t_unmapped;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule